// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Reset Origin Tracking

This block decides when the device drops into one of three low-power modes and when it returns to run. Software selects a target mode through a small write port. The block enters that mode only when the processor reports that it is waiting for an interrupt with its deep-sleep flag raised, and only while no debug hold line is high. While the device is in a low-power mode, any wake line whose enable bit is set brings it back to run.

The same block tracks where the last reset came from, in a two-bit origin code that only a power-on reset clears. It also holds a clock-loss-detect enable. Two copies of this enable exist: one in the register file and one in an always-on copy that follows it through a short pipeline. A software write can request a warm reset. An enabled clock-loss event raises the same request.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: After `por_ni` is released, `mode_o` is 00, `cause_o` is 00, `warm_req_o` is 0, `loss_en_o` is 0 and `loss_valid_o` is 1.
- R2: The mode codes are 00 run, 01 light, 10 medium and 11 deep. Write address 0 (data bits [1:0]) sets the target mode. When `mode_o` is 00, and `wfi_i` and `deep_i` are both high, and no `dbg_hold_i` bit is set, `mode_o` takes the target value at the next clock edge. A target of 00 causes no change.
- R3: While `wfi_i` or `deep_i` is low, `mode_o` stays at 00.
- R4: While any `dbg_hold_i` bit is high, `mode_o` stays at 00.
- R5: Write address 1 sets the wake enables. Bit 0 to bit 3 are GPIO ports A to D, bit 4 is USB and bit 5 is the sleep timer, and 1 enables the source. When `mode_o` is not 00, a one-cycle pulse on an enabled `wake_i` bit returns `mode_o` to 00 at the next edge. A pulse on a disabled bit has no effect.
- R6: `ext_rst_i` records origin 01 and `wdt_rst_i` records origin 10 at the next edge. When events coincide, the priority is clock-loss/software (11), then watchdog (10), then external (01).
- R7: A write of 1 to address 3 bit 0 raises `warm_req_o` for exactly one cycle after the write edge and sets `cause_o` to 11. A write of 0 to that bit does nothing.
- R8: When `loss_en_o` is 1, a `loss_evt_i` pulse raises `warm_req_o` for one cycle and sets `cause_o` to 11. When `loss_en_o` is 0, the pulse is ignored.
- R9: A write to address 2 (bit 0) that changes the enable is accepted when `loss_valid_o` is 1. `loss_valid_o` then reads 0 for two cycles, and `loss_en_o` takes the new value two cycles after the write edge.
- R10: Writes to address 2 while `loss_valid_o` is 0 are ignored.
- R11: Any warm event clears the target mode and the wake enables and returns `mode_o` to 00. The warm events are external, watchdog, an enabled clock loss and a software-forced reset. A warm event leaves `cause_o` holding the new origin and does not touch the clock-loss enable. Only `por_ni` returns `cause_o` to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | N_WAKE | Register write data |
| wfi_i | input | 1 | Processor waits for interrupt |
| deep_i | input | 1 | Processor deep-sleep flag |
| wake_i | input | N_WAKE | Wake request lines |
| dbg_hold_i | input | N_DBG | Debug lines that inhibit power-down |
| ext_rst_i | input | 1 | External reset event pulse |
| wdt_rst_i | input | 1 | Watchdog reset event pulse |
| loss_evt_i | input | 1 | Clock-loss event pulse |
| mode_o | output | 2 | Current power mode |
| cause_o | output | 2 | Origin of the last reset |
| warm_req_o | output | 1 | Warm-reset request pulse |
| loss_en_o | output | 1 | Always-on clock-loss enable |
| loss_valid_o | output | 1 | Register and always-on enable copies agree |

## Verification
Mode changes, origin codes and the warm-reset pulse all settle one edge after the stimulus. The always-on enable follows a write by two edges, and the valid flag is low during those two edges. The bench drives every input on the falling edge and samples one falling edge later for single-edge results. For the enable copy, it samples after each of the two following edges, so that both the valid window and the moment the enable lands are checked. Writes made inside the valid window are checked by confirming that the enable and the valid flag keep their settled values afterwards.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_LIGHT = 2'b01,
        PM_MED   = 2'b10,
        PM_DEEP  = 2'b11
    } pm_e;

    typedef enum logic [1:0] {
        ORG_POR  = 2'b00,
        ORG_EXT  = 2'b01,
        ORG_WDT  = 2'b10,
        ORG_LOSS = 2'b11
    } origin_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_MODE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_WAKE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOSS  = 2'd2;
    localparam logic [ADDR_W-1:0] A_FORCE = 2'd3;
endpackage

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_rst_pkg::*;
#(
    parameter int N_WAKE = 6,
    parameter int N_DBG  = 2
) (
    input  logic              clk,
    input  logic              por_ni,
    input  logic              warm_i,
    input  logic              wfi_i,
    input  logic              deep_i,
    input  logic [N_DBG-1:0]  dbg_i,
    input  logic [1:0]        target_i,
    input  logic [N_WAKE-1:0] wake_i,
    input  logic [N_WAKE-1:0] wake_en_i,
    output logic [1:0]        mode_o
);
    typedef struct packed {
        logic [1:0] mode;
    } seq_t;

    seq_t seq_d, seq_q;
    logic enter_ok;
    logic wake_hit;

    assign enter_ok = wfi_i && deep_i && (dbg_i == '0) && (target_i != PM_RUN);
    assign wake_hit = |(wake_i & wake_en_i);

    always_comb begin
        seq_d = seq_q;
        if (warm_i) begin
            seq_d.mode = PM_RUN;
        end else if (seq_q.mode == PM_RUN) begin
            if (enter_ok) seq_d.mode = target_i;
        end else if (wake_hit) begin
            seq_d.mode = PM_RUN;
        end
    end

    always_ff @(posedge clk or negedge por_ni) begin
        if (!por_ni) seq_q <= '{mode: PM_RUN};
        else         seq_q <= seq_d;
    end

    assign mode_o = seq_q.mode;
endmodule

// File: rtl/rst_origin_rec.sv
module rst_origin_rec
    import pwr_rst_pkg::*;
(
    input  logic       clk,
    input  logic       por_ni,
    input  logic       ext_i,
    input  logic       wdt_i,
    input  logic       loss_trig_i,
    output logic [1:0] origin_o,
    output logic       req_o
);
    typedef struct packed {
        logic [1:0] origin;
        logic       req;
    } org_t;

    org_t org_d, org_q;

    always_comb begin
        org_d     = org_q;
        org_d.req = loss_trig_i;
        if (loss_trig_i)  org_d.origin = ORG_LOSS;
        else if (wdt_i)   org_d.origin = ORG_WDT;
        else if (ext_i)   org_d.origin = ORG_EXT;
    end

    always_ff @(posedge clk or negedge por_ni) begin
        if (!por_ni) org_q <= '{origin: ORG_POR, req: 1'b0};
        else         org_q <= org_d;
    end

    assign origin_o = org_q.origin;
    assign req_o    = org_q.req;
endmodule

// File: rtl/loss_en_shadow.sv
module loss_en_shadow #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_ni,
    input  logic wr_i,
    input  logic val_i,
    output logic en_o,
    output logic valid_o
);
    typedef struct packed {
        logic              regv;
        logic [STAGES-1:0] chain;
    } shd_t;

    shd_t shd_d, shd_q;
    logic agree;

    assign agree = (shd_q.regv == shd_q.chain[STAGES-1]);

    always_comb begin
        shd_d = shd_q;
        if (wr_i && agree) shd_d.regv = val_i;
        shd_d.chain[0] = shd_q.regv;
        for (int i = 1; i < STAGES; i++) begin
            shd_d.chain[i] = shd_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_ni) begin
        if (!por_ni) shd_q <= '0;
        else         shd_q <= shd_d;
    end

    assign en_o    = shd_q.chain[STAGES-1];
    assign valid_o = agree;
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
    import pwr_rst_pkg::*;
#(
    parameter int N_WAKE      = 6,
    parameter int N_DBG       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [N_WAKE-1:0] wr_data_i,
    input  logic              wfi_i,
    input  logic              deep_i,
    input  logic [N_WAKE-1:0] wake_i,
    input  logic [N_DBG-1:0]  dbg_hold_i,
    input  logic              ext_rst_i,
    input  logic              wdt_rst_i,
    input  logic              loss_evt_i,
    output logic [1:0]        mode_o,
    output logic [1:0]        cause_o,
    output logic              warm_req_o,
    output logic              loss_en_o,
    output logic              loss_valid_o
);
    typedef struct packed {
        logic [1:0]        target;
        logic [N_WAKE-1:0] wake_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic force_hit;
    logic loss_wr;
    logic loss_trig;
    logic warm_evt;

    assign force_hit = wr_en_i && (wr_addr_i == A_FORCE) && wr_data_i[0];
    assign loss_wr   = wr_en_i && (wr_addr_i == A_LOSS);
    assign loss_trig = force_hit || (loss_evt_i && loss_en_o);
    assign warm_evt  = loss_trig || ext_rst_i || wdt_rst_i;

    always_comb begin
        cfg_d = cfg_q;
        if (warm_evt) begin
            cfg_d = '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_MODE) cfg_d.target  = wr_data_i[1:0];
            if (wr_addr_i == A_WAKE) cfg_d.wake_en = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge por_ni) begin
        if (!por_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    pwr_mode_seq #(.N_WAKE(N_WAKE), .N_DBG(N_DBG)) u_seq (
        .clk       (clk),
        .por_ni    (por_ni),
        .warm_i    (warm_evt),
        .wfi_i     (wfi_i),
        .deep_i    (deep_i),
        .dbg_i     (dbg_hold_i),
        .target_i  (cfg_q.target),
        .wake_i    (wake_i),
        .wake_en_i (cfg_q.wake_en),
        .mode_o    (mode_o)
    );

    rst_origin_rec u_org (
        .clk         (clk),
        .por_ni      (por_ni),
        .ext_i       (ext_rst_i),
        .wdt_i       (wdt_rst_i),
        .loss_trig_i (loss_trig),
        .origin_o    (cause_o),
        .req_o       (warm_req_o)
    );

    loss_en_shadow #(.STAGES(SYNC_STAGES)) u_shd (
        .clk     (clk),
        .por_ni  (por_ni),
        .wr_i    (loss_wr),
        .val_i   (wr_data_i[0]),
        .en_o    (loss_en_o),
        .valid_o (loss_valid_o)
    );
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk #(
    parameter int N_WAKE = 6,
    parameter int N_DBG  = 2
) (
    input logic              clk,
    input logic              por_ni,
    input logic              wr_en_i,
    input logic [1:0]        wr_addr_i,
    input logic [N_WAKE-1:0] wr_data_i,
    input logic              wfi_i,
    input logic              deep_i,
    input logic [N_DBG-1:0]  dbg_hold_i,
    input logic              ext_rst_i,
    input logic              wdt_rst_i,
    input logic              loss_evt_i,
    input logic [1:0]        mode_o,
    input logic [1:0]        cause_o,
    input logic              warm_req_o,
    input logic              loss_en_o,
    input logic              loss_valid_o
);
    a_r3_needs_wfi_and_deep: assert property (@(posedge clk) disable iff (!por_ni)
        (mode_o == 2'b00 && !(wfi_i && deep_i)) |=> (mode_o == 2'b00));

    a_r4_debug_blocks_entry: assert property (@(posedge clk) disable iff (!por_ni)
        (mode_o == 2'b00 && dbg_hold_i != '0) |=> (mode_o == 2'b00));

    a_r7_req_implies_loss_origin: assert property (@(posedge clk) disable iff (!por_ni)
        warm_req_o |-> (cause_o == 2'b11));

    a_r9_enable_moves_when_agreeing: assert property (@(posedge clk) disable iff (!por_ni)
        !$stable(loss_en_o) |-> loss_valid_o);

    a_r11_origin_held: assert property (@(posedge clk) disable iff (!por_ni)
        (!ext_rst_i && !wdt_rst_i && !loss_evt_i &&
         !(wr_en_i && wr_addr_i == 2'd3 && wr_data_i[0])) |=> $stable(cause_o));
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk #(.N_WAKE(N_WAKE), .N_DBG(N_DBG)) i_chk (
    .clk          (clk),
    .por_ni       (por_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .wfi_i        (wfi_i),
    .deep_i       (deep_i),
    .dbg_hold_i   (dbg_hold_i),
    .ext_rst_i    (ext_rst_i),
    .wdt_rst_i    (wdt_rst_i),
    .loss_evt_i   (loss_evt_i),
    .mode_o       (mode_o),
    .cause_o      (cause_o),
    .warm_req_o   (warm_req_o),
    .loss_en_o    (loss_en_o),
    .loss_valid_o (loss_valid_o)
);

// File: tb/test_pwr_rst_ctrl.sv
module test_pwr_rst_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_WAKE = 6;
    localparam int N_DBG  = 2;

    logic              clk = 1'b0;
    logic              por_ni = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [1:0]        wr_addr_i = '0;
    logic [N_WAKE-1:0] wr_data_i = '0;
    logic              wfi_i = 1'b0;
    logic              deep_i = 1'b0;
    logic [N_WAKE-1:0] wake_i = '0;
    logic [N_DBG-1:0]  dbg_hold_i = '0;
    logic              ext_rst_i = 1'b0;
    logic              wdt_rst_i = 1'b0;
    logic              loss_evt_i = 1'b0;
    logic [1:0]        mode_o;
    logic [1:0]        cause_o;
    logic              warm_req_o;
    logic              loss_en_o;
    logic              loss_valid_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_rst_ctrl #(.N_WAKE(N_WAKE), .N_DBG(N_DBG), .SYNC_STAGES(2)) i_pwr_rst_ctrl (
        .clk(clk), .por_ni(por_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .wfi_i(wfi_i), .deep_i(deep_i), .wake_i(wake_i),
        .dbg_hold_i(dbg_hold_i), .ext_rst_i(ext_rst_i), .wdt_rst_i(wdt_rst_i),
        .loss_evt_i(loss_evt_i), .mode_o(mode_o), .cause_o(cause_o),
        .warm_req_o(warm_req_o), .loss_en_o(loss_en_o), .loss_valid_o(loss_valid_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [N_WAKE-1:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic do_por();
        por_ni = 1'b0;
        tick();
        por_ni = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_por();
        chk("R1 mode", mode_o, 0);
        chk("R1 cause", cause_o, 0);
        chk("R1 req", warm_req_o, 0);
        chk("R1 loss_en", loss_en_o, 0);
        chk("R1 valid", loss_valid_o, 1);
    endtask

    task automatic t_entry_wake();
        wr(2'd0, 6'd0);
        wfi_i = 1; deep_i = 1; tick();
        chk("R2 zero target", mode_o, 0);
        wfi_i = 0; deep_i = 0;
        wr(2'd0, 6'd2);
        wr(2'd1, 6'b010000);
        wfi_i = 1; deep_i = 1; tick();
        chk("R2 enter medium", mode_o, 2);
        wfi_i = 0; deep_i = 0;
        wake_i = 6'b000001; tick(); wake_i = '0;
        chk("R5 disabled wake", mode_o, 2);
        wake_i = 6'b010000; tick(); wake_i = '0;
        chk("R5 enabled wake", mode_o, 0);
    endtask

    task automatic t_conditions();
        wr(2'd0, 6'd3);
        wfi_i = 1; deep_i = 0; tick();
        chk("R3 no deep", mode_o, 0);
        wfi_i = 0; deep_i = 1; tick();
        chk("R3 no wfi", mode_o, 0);
        dbg_hold_i = 2'b10; wfi_i = 1; tick();
        chk("R4 debug hold", mode_o, 0);
        dbg_hold_i = 2'b00; tick();
        chk("R4 release", mode_o, 3);
        wfi_i = 0; deep_i = 0;
        wr(2'd1, 6'b100000);
        wake_i = 6'b100000; tick(); wake_i = '0;
        chk("R5 timer wake", mode_o, 0);
    endtask

    task automatic t_origin();
        do_por();
        ext_rst_i = 1; tick(); ext_rst_i = 0;
        chk("R6 external", cause_o, 1);
        wdt_rst_i = 1; tick(); wdt_rst_i = 0;
        chk("R6 watchdog", cause_o, 2);
        ext_rst_i = 1; wdt_rst_i = 1; tick(); ext_rst_i = 0; wdt_rst_i = 0;
        chk("R6 priority", cause_o, 2);
        ext_rst_i = 1; wr(2'd3, 6'd1); ext_rst_i = 0;
        chk("R6 loss over ext", cause_o, 3);
        tick();
        chk("R6 held", cause_o, 3);
    endtask

    task automatic t_force();
        ext_rst_i = 1; tick(); ext_rst_i = 0;
        wr(2'd3, 6'd0);
        chk("R7 zero write req", warm_req_o, 0);
        chk("R7 zero write origin", cause_o, 1);
        wr(2'd3, 6'd1);
        chk("R7 pulse", warm_req_o, 1);
        chk("R7 origin", cause_o, 3);
        tick();
        chk("R7 one cycle", warm_req_o, 0);
    endtask

    task automatic t_loss();
        do_por();
        ext_rst_i = 1; tick(); ext_rst_i = 0;
        loss_evt_i = 1; tick(); loss_evt_i = 0;
        chk("R8 disabled req", warm_req_o, 0);
        chk("R8 disabled origin", cause_o, 1);
        wr(2'd2, 6'd1);
        chk("R9 valid low 1", loss_valid_o, 0);
        chk("R9 en old 1", loss_en_o, 0);
        wr(2'd2, 6'd0);
        chk("R9 valid low 2", loss_valid_o, 0);
        chk("R9 en old 2", loss_en_o, 0);
        tick();
        chk("R9 en new", loss_en_o, 1);
        chk("R9 valid back", loss_valid_o, 1);
        tick(); tick();
        chk("R10 ignored en", loss_en_o, 1);
        chk("R10 ignored valid", loss_valid_o, 1);
        loss_evt_i = 1; tick(); loss_evt_i = 0;
        chk("R8 enabled req", warm_req_o, 1);
        chk("R8 enabled origin", cause_o, 3);
        chk("R11 enable kept", loss_en_o, 1);
    endtask

    task automatic t_warm_clears();
        do_por();
        wr(2'd0, 6'd1);
        wr(2'd1, 6'b000100);
        wdt_rst_i = 1; tick(); wdt_rst_i = 0;
        wfi_i = 1; deep_i = 1; tick();
        chk("R11 target cleared", mode_o, 0);
        wfi_i = 0; deep_i = 0;
        wr(2'd0, 6'd1);
        wfi_i = 1; deep_i = 1; tick(); wfi_i = 0; deep_i = 0;
        chk("R11 reenter", mode_o, 1);
        wake_i = 6'b000100; tick(); wake_i = '0;
        chk("R11 wake enables cleared", mode_o, 1);
        ext_rst_i = 1; tick(); ext_rst_i = 0;
        chk("R11 warm to run", mode_o, 0);
        chk("R11 origin survives", cause_o, 1);
        do_por();
        chk("R11 por clears origin", cause_o, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_entry_wake();
        t_conditions();
        t_origin();
        t_force();
        t_loss();
        t_warm_clears();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule